// File: doc/BRIEF.md
# Masked Word Fuse Programming Sequencer

This block programs one data word into a one-time-programmable fuse array. It is built as a small sequencer. A request gives a byte offset and a data word. The sequencer first checks the offset. It then reads the word that is stored there now and drops every bit that is already blown. Each remaining bit is sent to the fuse controller as its own single-bit program command. After each command the sequencer waits out a settle time and reads the word back to confirm that the bit took.

All waits are counted in ticks, and a tick is a fixed number of clock cycles. The sequencer stops at the first problem it meets and returns that result. The result appears on a status code together with a one-cycle done pulse. The fuse controller and the host bus are not part of this block. The block only drives a command/start/busy port and a word-read port with one cycle of latency.

Top module: `fuse_word_prog`

## Requirements
- R1: A request whose offset is not below ARRAY_BYTES, or whose two low bits are not zero, finishes with status 1 (bad parameter). It issues no command and no read.
- R2: The stored word is read before any command is issued. A bit that is already 1 in the array is never commanded. If no bit is left to program, the request finishes with status 0 and no command.
- R3: Commands go out in ascending position: byte offset first, then bit 0 to 7 within the byte. Zero bits get no command.
- R4: A command names its byte offset as cmd_macro = offset mod NUM_MACROS and cmd_row = offset / NUM_MACROS, with cmd_bit giving the bit within that byte.
- R5: Before each command, cmd_busy may stay high for up to IDLE_WAIT_TICKS ticks. If it is still high when that limit is reached, the request finishes with status 2 (busy) and the command is not issued. A shorter busy period only delays the command.
- R6: After a command, cmd_busy must be high from the next cycle and must fall within DONE_WAIT_TICKS ticks. If it does not, the request finishes with status 3 (timeout).
- R7: The readback of a commanded bit starts no earlier than SETTLE_TICKS*TICK_CYCLES cycles after cmd_busy falls. If the bit reads 0, the request finishes with status 4 (write error).
- R8: After the first non-zero status, no further command is issued for that request.
- R9: done is high for exactly one cycle per accepted request. status changes only in a done cycle. A req_valid that arrives while a request is in progress is ignored.
- R10: cmd_start is a one-cycle pulse and is raised only in a cycle where cmd_busy is low.
- R11: When no error occurs, the status is 0 and the array word ends as the old word OR the requested data.
- R12: rd_data carries the word at rd_word_addr one cycle after rd_en; after reset, done, cmd_start and rd_en are low and status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_offset | input | ADDR_W | Byte offset of the target word |
| req_data | input | WORD_W | Bits to program |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 bad parameter, 2 busy, 3 timeout, 4 write error |
| rd_en | output | 1 | Word read request |
| rd_word_addr | output | log2(ARRAY_BYTES)-log2(WORD_W/8) | Word index to read |
| rd_data | input | WORD_W | Read data, one cycle after rd_en |
| cmd_start | output | 1 | Single-bit program command strobe |
| cmd_macro | output | max(1,log2(NUM_MACROS)) | Target macro of the command |
| cmd_row | output | log2(ARRAY_BYTES/NUM_MACROS) | Byte row within the macro |
| cmd_bit | output | 3 | Bit within the byte |
| cmd_busy | input | 1 | Controller busy or command in progress |

## Verification
The hardest case to reach is a failure in the middle of a word. This is a bit that does not blow, or a controller that hangs, after other bits were already programmed. That case is the one that shows whether the sequencer really stops at the first failure. The bench models the controller with a programmable busy length and a stuck fuse position. This lets it force a write error on the third pending bit or a timeout on the first command, and then count the commands that follow. The busy-before-start window is reached by holding the controller busy from outside, once past the limit and once shorter than it.

// File: rtl/fuse_prog_pkg.sv
package fuse_prog_pkg;

   typedef enum logic [2:0] {
      FP_OK        = 3'd0,
      FP_BAD_PARAM = 3'd1,
      FP_BUSY      = 3'd2,
      FP_TIMEOUT   = 3'd3,
      FP_WRITE_ERR = 3'd4
   } fp_status_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_FETCH,
      S_LOAD,
      S_SCAN,
      S_WAIT_IDLE,
      S_ARM,
      S_WAIT_DONE,
      S_SETTLE,
      S_CHECK
   } fp_state_e;

endpackage

// File: rtl/fuse_prog_timer.sv
module fuse_prog_timer #(
   parameter int TICK_CYCLES = 48,
   parameter int CNT_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);

   logic             tick;
   logic [CNT_W-1:0] tick_q;

   generate
      if (TICK_CYCLES == 1) begin : g_every_cycle
         assign tick = 1'b1;
      end else begin : g_divided
         localparam int CYC_W = $clog2(TICK_CYCLES);
         logic [CYC_W-1:0] cyc_q;
         assign tick = (cyc_q == CYC_W'(TICK_CYCLES - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cyc_q <= '0;
            else if (restart) cyc_q <= '0;
            else if (tick)    cyc_q <= '0;
            else              cyc_q <= cyc_q + CYC_W'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       tick_q <= '0;
      else if (restart)                 tick_q <= '0;
      else if (tick && (tick_q != '1))  tick_q <= tick_q + CNT_W'(1);
   end

   assign expired = (tick_q >= limit);

   // tick count only moves upward between restarts (R5, R6, R7 windows)
   assert_tick_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> (tick_q >= $past(tick_q)));

endmodule

// File: rtl/fuse_lowbit_pick.sv
module fuse_lowbit_pick #(
   parameter int N     = 32,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   always_comb begin
      idx = '0;
      any = |vec;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/fuse_addr_split.sv
module fuse_addr_split #(
   parameter int BYTE_W     = 7,
   parameter int NUM_MACROS = 4,
   parameter int MACRO_W    = 2,
   parameter int ROW_W      = 5
) (
   input  logic [BYTE_W-1:0]  byte_ofs,
   output logic [MACRO_W-1:0] macro,
   output logic [ROW_W-1:0]   row
);

   generate
      if (NUM_MACROS == 1) begin : g_single
         assign macro = '0;
         assign row   = ROW_W'(byte_ofs);
      end else begin : g_interleaved
         localparam int SH = $clog2(NUM_MACROS);
         assign macro = byte_ofs[SH-1:0];
         assign row   = ROW_W'(byte_ofs >> SH);
      end
   endgenerate

endmodule

// File: rtl/fuse_word_prog.sv
module fuse_word_prog
   import fuse_prog_pkg::*;
#(
   parameter int WORD_W          = 32,
   parameter int ARRAY_BYTES     = 128,
   parameter int NUM_MACROS      = 4,
   parameter int ADDR_W          = 16,
   parameter int TICK_CYCLES     = 48,
   parameter int IDLE_WAIT_TICKS = 10,
   parameter int DONE_WAIT_TICKS = 10,
   parameter int SETTLE_TICKS    = 100,
   localparam int BYTES_PER_WORD = WORD_W / 8,
   localparam int SEL_W          = $clog2(BYTES_PER_WORD),
   localparam int BYTE_W         = $clog2(ARRAY_BYTES),
   localparam int WADDR_W        = BYTE_W - SEL_W,
   localparam int MACRO_W        = (NUM_MACROS > 1) ? $clog2(NUM_MACROS) : 1,
   localparam int ROW_W          = $clog2(ARRAY_BYTES / NUM_MACROS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [ADDR_W-1:0]  req_offset,
   input  logic [WORD_W-1:0]  req_data,
   output logic               done,
   output logic [2:0]         status,
   output logic               rd_en,
   output logic [WADDR_W-1:0] rd_word_addr,
   input  logic [WORD_W-1:0]  rd_data,
   output logic               cmd_start,
   output logic [MACRO_W-1:0] cmd_macro,
   output logic [ROW_W-1:0]   cmd_row,
   output logic [2:0]         cmd_bit,
   input  logic               cmd_busy
);

   localparam int POS_W   = $clog2(WORD_W);
   localparam int MAX_LIM = (IDLE_WAIT_TICKS > DONE_WAIT_TICKS)
                            ? ((IDLE_WAIT_TICKS > SETTLE_TICKS) ? IDLE_WAIT_TICKS : SETTLE_TICKS)
                            : ((DONE_WAIT_TICKS > SETTLE_TICKS) ? DONE_WAIT_TICKS : SETTLE_TICKS);
   localparam int CNT_W   = $clog2(MAX_LIM + 1);

   // elaboration-time parameter checks
   generate
      if (WORD_W < 16 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
         $error("WORD_W must be a power of two of at least 16");
      end
      if ((ARRAY_BYTES & (ARRAY_BYTES - 1)) != 0 || ARRAY_BYTES < BYTES_PER_WORD) begin : g_bad_array
         $error("ARRAY_BYTES must be a power of two holding at least one word");
      end
      if ((NUM_MACROS & (NUM_MACROS - 1)) != 0 || NUM_MACROS > ARRAY_BYTES / 2) begin : g_bad_macros
         $error("NUM_MACROS must be a power of two below ARRAY_BYTES");
      end
      if (ADDR_W <= BYTE_W || ADDR_W >= 32) begin : g_bad_addr
         $error("ADDR_W must exceed the array index width and stay below 32");
      end
      if (TICK_CYCLES < 1 || IDLE_WAIT_TICKS < 1 || DONE_WAIT_TICKS < 1 || SETTLE_TICKS < 1) begin : g_bad_time
         $error("tick length and all wait limits must be at least 1");
      end
   endgenerate

   fp_state_e              state_q, state_d;
   fp_status_e             status_q, fin_code;
   logic                   done_q, fin;
   logic [WADDR_W-1:0]     base_q;
   logic [WORD_W-1:0]      pending_q;
   logic [POS_W-1:0]       pos_q;
   logic [POS_W-1:0]       pick_idx;
   logic                   pick_any;
   logic [CNT_W-1:0]       limit;
   logic                   expired;
   logic                   ofs_ok;
   logic [BYTE_W-1:0]      cmd_byte;

   assign ofs_ok = (req_offset < ADDR_W'(ARRAY_BYTES)) && (req_offset[SEL_W-1:0] == '0);

   fuse_lowbit_pick #(.N(WORD_W), .IDX_W(POS_W)) i_pick (
      .vec (pending_q),
      .idx (pick_idx),
      .any (pick_any)
   );

   fuse_prog_timer #(.TICK_CYCLES(TICK_CYCLES), .CNT_W(CNT_W)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (state_d != state_q),
      .limit   (limit),
      .expired (expired)
   );

   assign cmd_byte = {base_q, pos_q[POS_W-1:3]};
   assign cmd_bit  = pos_q[2:0];

   fuse_addr_split #(
      .BYTE_W(BYTE_W), .NUM_MACROS(NUM_MACROS), .MACRO_W(MACRO_W), .ROW_W(ROW_W)
   ) i_split (
      .byte_ofs (cmd_byte),
      .macro    (cmd_macro),
      .row      (cmd_row)
   );

   always_comb begin
      state_d   = state_q;
      cmd_start = 1'b0;
      rd_en     = 1'b0;
      fin       = 1'b0;
      fin_code  = FP_OK;
      limit     = CNT_W'(MAX_LIM);
      case (state_q)
         S_IDLE: begin
            if (req_valid) begin
               if (!ofs_ok) begin
                  fin      = 1'b1;
                  fin_code = FP_BAD_PARAM;
               end else begin
                  state_d = S_FETCH;
               end
            end
         end
         S_FETCH: begin
            rd_en   = 1'b1;
            state_d = S_LOAD;
         end
         S_LOAD: state_d = S_SCAN;
         S_SCAN: begin
            if (!pick_any) fin = 1'b1;
            else           state_d = S_WAIT_IDLE;
         end
         S_WAIT_IDLE: begin
            limit = CNT_W'(IDLE_WAIT_TICKS);
            if (!cmd_busy) begin
               cmd_start = 1'b1;
               state_d   = S_ARM;
            end else if (expired) begin
               fin      = 1'b1;
               fin_code = FP_BUSY;
            end
         end
         S_ARM: state_d = S_WAIT_DONE;
         S_WAIT_DONE: begin
            limit = CNT_W'(DONE_WAIT_TICKS);
            if (!cmd_busy) begin
               state_d = S_SETTLE;
            end else if (expired) begin
               fin      = 1'b1;
               fin_code = FP_TIMEOUT;
            end
         end
         S_SETTLE: begin
            limit = CNT_W'(SETTLE_TICKS);
            if (expired) begin
               rd_en   = 1'b1;
               state_d = S_CHECK;
            end
         end
         S_CHECK: begin
            if (rd_data[pos_q]) begin
               state_d = S_SCAN;
            end else begin
               fin      = 1'b1;
               fin_code = FP_WRITE_ERR;
            end
         end
         default: state_d = S_IDLE;
      endcase
      if (fin) state_d = S_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         status_q  <= FP_OK;
         done_q    <= 1'b0;
         base_q    <= '0;
         pending_q <= '0;
         pos_q     <= '0;
      end else begin
         state_q <= state_d;
         done_q  <= fin;
         if (fin) status_q <= fin_code;
         if (state_q == S_IDLE && req_valid && ofs_ok) begin
            base_q    <= req_offset[BYTE_W-1:SEL_W];
            pending_q <= req_data;
         end
         if (state_q == S_LOAD)                pending_q <= pending_q & ~rd_data;
         if (state_q == S_SCAN && pick_any)    pos_q <= pick_idx;
         if (state_q == S_CHECK && rd_data[pos_q]) pending_q[pos_q] <= 1'b0;
      end
   end

   assign done         = done_q;
   assign status       = status_q;
   assign rd_word_addr = base_q;

   // ---------------- assertions ----------------
   assert_start_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> !cmd_busy);

   assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> !cmd_start);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(status));

   assert_bad_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && req_valid && !ofs_ok) |=> (done && status == FP_BAD_PARAM));

   assert_lowest_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> ((pending_q & ((WORD_W'(1) << pos_q) - WORD_W'(1))) == '0));

endmodule

// File: tb/test_fuse_word_prog.sv
module test_fuse_word_prog;

   localparam int WORD_W = 32;
   localparam int ARRAY_BYTES = 128;
   localparam int NUM_MACROS = 4;
   localparam int ADDR_W = 16;
   localparam int TICKC = 2;
   localparam int IDLE_T = 10;
   localparam int DONE_T = 10;
   localparam int SETTLE_T = 8;
   localparam int ST_OK = 0, ST_BAD = 1, ST_BUSY = 2, ST_TMO = 3, ST_WERR = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_offset = '0;
   logic [WORD_W-1:0] req_data = '0;
   logic              done;
   logic [2:0]        status;
   logic              rd_en;
   logic [4:0]        rd_word_addr;
   logic [WORD_W-1:0] rd_data = '0;
   logic              cmd_start;
   logic [1:0]        cmd_macro;
   logic [4:0]        cmd_row;
   logic [2:0]        cmd_bit;
   logic              cmd_busy;

   always #4 clk = ~clk;

   fuse_word_prog #(
      .WORD_W(WORD_W), .ARRAY_BYTES(ARRAY_BYTES), .NUM_MACROS(NUM_MACROS), .ADDR_W(ADDR_W),
      .TICK_CYCLES(TICKC), .IDLE_WAIT_TICKS(IDLE_T), .DONE_WAIT_TICKS(DONE_T),
      .SETTLE_TICKS(SETTLE_T)
   ) i_fuse_word_prog (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
      .req_data(req_data), .done(done), .status(status), .rd_en(rd_en),
      .rd_word_addr(rd_word_addr), .rd_data(rd_data), .cmd_start(cmd_start),
      .cmd_macro(cmd_macro), .cmd_row(cmd_row), .cmd_bit(cmd_bit), .cmd_busy(cmd_busy)
   );

   // ---------------- fuse array and controller model ----------------
   logic [7:0] mem [ARRAY_BYTES];
   int  busy_cnt = 0;
   int  blow_delay = 3;
   logic force_busy = 1'b0;
   int  stuck_pos = -1;
   int  pend_byte = 0, pend_bit = 0;
   int  cyc = 0, fall_cyc = 0, min_gap = 1 << 30;
   bit  await_rb = 0;
   int  cmd_count = 0, rd_count = 0, done_count = 0, last_p = -1;
   bit  order_err = 0, repeat_err = 0, addr_err = 0, spur_err = 0, busy_start_err = 0;
   int  exp_base = 0;
   logic [WORD_W-1:0] exp_data = '0;

   assign cmd_busy = force_busy || (busy_cnt != 0);

   always @(posedge clk) begin
      int a;
      a = int'(rd_word_addr) * 4;
      cyc++;
      if (rd_en) begin
         rd_data <= {mem[a+3], mem[a+2], mem[a+1], mem[a]};
         rd_count++;
         if (await_rb && busy_cnt == 0) begin
            if (cyc - fall_cyc < min_gap) min_gap = cyc - fall_cyc;
            await_rb = 0;
         end
      end
      if (done) done_count++;
      if (cmd_start) begin
         int bo, p;
         bo = int'(cmd_row) * NUM_MACROS + int'(cmd_macro);
         if (cmd_busy) busy_start_err = 1;
         if (bo < exp_base || bo >= exp_base + 4) begin
            addr_err = 1;
            p = last_p + 1;
         end else begin
            p = (bo - exp_base) * 8 + int'(cmd_bit);
            if (!exp_data[p]) spur_err = 1;
         end
         if (p <= last_p) order_err = 1;
         last_p = p;
         if (mem[bo][cmd_bit]) repeat_err = 1;
         cmd_count++;
         pend_byte = bo;
         pend_bit = int'(cmd_bit);
         busy_cnt <= blow_delay;
         await_rb = 1;
      end else if (busy_cnt != 0) begin
         if (busy_cnt == 1) begin
            if (pend_byte * 8 + pend_bit != stuck_pos) mem[pend_byte][pend_bit] <= 1'b1;
            fall_cyc = cyc;
         end
         busy_cnt <= busy_cnt - 1;
      end
   end

   // ---------------- bench helpers ----------------
   int errs = 0, checks = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < ARRAY_BYTES; i++) mem[i] = 8'h00;
   endtask

   task automatic set_word(input int ofs, input logic [31:0] w);
      for (int i = 0; i < 4; i++) mem[ofs + i] = w[8*i +: 8];
   endtask

   function automatic logic [31:0] get_word(input int ofs);
      return {mem[ofs+3], mem[ofs+2], mem[ofs+1], mem[ofs]};
   endfunction

   function automatic int popc(input logic [31:0] v);
      int n = 0;
      for (int i = 0; i < 32; i++) n += int'(v[i]);
      return n;
   endfunction

   task automatic start_req(input int ofs, input logic [31:0] d);
      cmd_count = 0; rd_count = 0; done_count = 0; last_p = -1;
      order_err = 0; repeat_err = 0; addr_err = 0; spur_err = 0; busy_start_err = 0;
      min_gap = 1 << 30; await_rb = 0;
      exp_base = ofs; exp_data = d;
      @(negedge clk);
      req_valid = 1'b1; req_offset = ADDR_W'(ofs); req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(output int st);
      int n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      st = int'(status);
      chk(done == 1'b1, "R9", "done seen", done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R9", "done one cycle", done, 0);
   endtask

   task automatic quiet();
      int n = 0;
      while (busy_cnt != 0 && n < 1000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic check_clean(input string tag);
      chk(!order_err, "R3", {tag, " ascending order"}, order_err, 0);
      chk(!repeat_err, "R2", {tag, " no blown bit commanded"}, repeat_err, 0);
      chk(!addr_err && !spur_err, "R4", {tag, " command address"}, addr_err | spur_err, 0);
      chk(!busy_start_err, "R10", {tag, " start while busy"}, busy_start_err, 0);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int st;
      logic [31:0] old_w, d_w, rv;
      clear_mem();
      rv = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 0 && cmd_start == 0 && rd_en == 0 && status == 0, "R12", "reset state",
          {done, cmd_start, rd_en, status}, 0);

      // R1: misaligned, at the end, far out of range
      foreach (rv[i]) if (i < 3) begin
         int ofs;
         ofs = (i == 0) ? 2 : (i == 1) ? ARRAY_BYTES : 16'hFFFC;
         start_req(ofs, 32'hFFFF_FFFF);
         wait_done(st);
         chk(st == ST_BAD, "R1", "bad offset status", st, ST_BAD);
         chk(cmd_count == 0 && rd_count == 0, "R1", "no command or read", cmd_count + rd_count, 0);
      end

      // R2: nothing left to program
      clear_mem(); set_word(40, 32'hF0F0_1234);
      start_req(40, 32'h1030_0204);
      wait_done(st);
      chk(st == ST_OK, "R2", "already programmed status", st, ST_OK);
      chk(cmd_count == 0 && rd_count == 1, "R2", "only one read", cmd_count * 16 + rd_count, 1);

      // R11 / R4: last word of the array
      clear_mem(); blow_delay = 2;
      start_req(ARRAY_BYTES - 4, 32'h8001_0081);
      wait_done(st);
      chk(st == ST_OK, "R11", "last word status", st, ST_OK);
      chk(get_word(ARRAY_BYTES - 4) == 32'h8001_0081, "R11", "last word content",
          get_word(ARRAY_BYTES - 4), 32'h8001_0081);
      check_clean("last word");

      // random words
      for (int it = 0; it < 24; it++) begin
         int ofs;
         logic [31:0] mask;
         clear_mem();
         ofs = int'($urandom % 32) * 4;
         old_w = $urandom & $urandom;
         d_w = $urandom;
         if (it == 0) d_w = 32'h0000_0001;
         if (it == 1) d_w = 32'hFFFF_FFFF;
         blow_delay = 1 + int'($urandom % 8);
         set_word(ofs, old_w);
         mask = d_w & ~old_w;
         start_req(ofs, d_w);
         wait_done(st);
         chk(st == ST_OK, "R11", "random status", st, ST_OK);
         chk(get_word(ofs) == (old_w | d_w), "R11", "random content", get_word(ofs), old_w | d_w);
         chk(cmd_count == popc(mask), "R2", "command count", cmd_count, popc(mask));
         check_clean("random");
         if (cmd_count > 0)
            chk(min_gap >= SETTLE_T * TICKC, "R7", "settle before readback", min_gap, SETTLE_T * TICKC);
         chk(done_count == 1, "R9", "one done per request", done_count, 1);
      end

      // R5: busy longer than the idle limit
      clear_mem(); force_busy = 1'b1;
      start_req(8, 32'h0000_0003);
      wait_done(st);
      force_busy = 1'b0;
      chk(st == ST_BUSY, "R5", "busy status", st, ST_BUSY);
      chk(cmd_count == 0, "R5", "no command when busy", cmd_count, 0);

      // R5: short busy only delays
      clear_mem(); force_busy = 1'b1; blow_delay = 2;
      start_req(12, 32'h0000_0300);
      repeat (8) @(negedge clk);
      force_busy = 1'b0;
      wait_done(st);
      chk(st == ST_OK, "R5", "short busy status", st, ST_OK);
      chk(get_word(12) == 32'h0000_0300, "R5", "short busy content", get_word(12), 32'h0000_0300);

      // R6 and R8: completion timeout on the first command
      clear_mem(); blow_delay = 60;
      start_req(20, 32'h0001_0011);
      wait_done(st);
      chk(st == ST_TMO, "R6", "timeout status", st, ST_TMO);
      chk(cmd_count == 1, "R8", "stop after timeout", cmd_count, 1);
      quiet();
      chk(cmd_count == 1, "R8", "no later command after timeout", cmd_count, 1);

      // R7 and R8: write error on third pending bit
      clear_mem(); blow_delay = 2; stuck_pos = 24 * 8 + 10;
      start_req(24, 32'h0000_0F00);
      wait_done(st);
      chk(st == ST_WERR, "R7", "write error status", st, ST_WERR);
      chk(cmd_count == 3, "R8", "stop at failing bit", cmd_count, 3);
      chk(get_word(24) == 32'h0000_0300, "R8", "content after error", get_word(24), 32'h0000_0300);
      stuck_pos = -1;
      repeat (40) @(negedge clk);
      chk(cmd_count == 3 && status == 3'(ST_WERR), "R9", "status held after done",
          status, ST_WERR);

      // R9: request during activity is ignored
      clear_mem(); blow_delay = 2;
      start_req(32, 32'h0000_00F0);
      repeat (20) @(negedge clk);
      req_valid = 1'b1; req_offset = 16'd36; req_data = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      wait_done(st);
      repeat (5) @(negedge clk);
      chk(st == ST_OK, "R9", "busy request status", st, ST_OK);
      chk(get_word(36) == 32'h0, "R9", "ignored request untouched", get_word(36), 0);
      chk(get_word(32) == 32'h0000_00F0, "R9", "first request content", get_word(32), 32'h0000_00F0);
      chk(done_count == 1, "R9", "single done", done_count, 1);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule